// File: doc/BRIEF.md
# RTC Alarm Interrupt Router

This block sits between a real-time clock's alarm comparators and its two open-drain style, active-low interrupt pins. It keeps a small control byte (routing mode and two alarm interrupt enables) and a status byte (oscillator-fault flag and two alarm flags). Single-cycle match pulses from the alarm comparators and a level oscillator-halted indication set the flags. Software reads both bytes through a simple register port and clears flags by writing zeros.

The routing-mode bit selects how the shared second pin is used. With the mode bit clear, that pin carries the square-wave source and both alarms interrupt on the primary pin. With the mode bit set, alarm 2 moves to the shared pin and alarm 1 keeps the primary pin. A flag whose enable is clear still latches and reads back, but it drives no pin.

Reset is asynchronous and active low. It is released to the logic through a synchronizer. The pins are decoded combinationally from the registered flags and enables, so a write that clears a flag or an enable takes effect on the next clock edge.

Top module: `rtc_irq_router`

## Requirements
- R1: After reset the control byte reads 0x00, the status byte reads 0x80 (oscillator-fault flag set, both alarm flags clear) and `inta_n` is high.
- R2: A write to the control address (default 0x0E) loads data bits 2..0: bit 2 is the routing mode, bit 1 is the alarm 2 enable and bit 0 is the alarm 1 enable. Bits 7..3 are ignored and read as 0.
- R3: The status address (default 0x0F) reads the oscillator-fault flag in bit 7, the alarm 2 flag in bit 1 and the alarm 1 flag in bit 0, with bits 6..2 reading 0. Any other address reads 0x00. Reads have no side effects.
- R4: A one-cycle `alarm1_hit` or `alarm2_hit` pulse sets the matching flag on that clock edge, and the flag stays set.
- R5: A status write with 0 in a flag's bit position clears that flag. A 1 in that position leaves the flag unchanged, so a write never sets a flag.
- R6: The oscillator-fault flag is set on every edge where `osc_halted` is high, and it is cleared only by a status write with bit 7 at 0.
- R7: When a set condition and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R8: `inta_n` is low whenever the alarm 1 flag and the alarm 1 enable are both 1, whatever the routing mode.
- R9: With the routing mode at 0, alarm 2 (flag and enable) drives `inta_n` low and `sqw_intb_n` follows `sqw_src`. With the routing mode at 1, alarm 2 drives `sqw_intb_n` low instead, and `sqw_intb_n` is high otherwise.
- R10: A flag whose enable is 0 still sets and reads back, but it drives no pin low.
- R11: A pin driven low by an alarm returns high at the clock edge that registers a clearing status write or a disabling control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm1_hit | input | 1 | Alarm 1 match pulse, one cycle |
| alarm2_hit | input | 1 | Alarm 2 match pulse, one cycle |
| osc_halted | input | 1 | High while the oscillator is stopped |
| sqw_src | input | 1 | Square-wave source for the shared pin |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| inta_n | output | 1 | Primary interrupt, active low |
| sqw_intb_n | output | 1 | Square wave or alarm 2 interrupt, active low |

## Verification
The bench goes after a set pulse and a clearing write that land in the same cycle. A design that gives the write priority would drop the event and read the flag back as 0. It writes all-ones to the status byte to catch a design that lets software set flags, and it flips the routing mode while both alarms are pending. A routing bug there would show alarm 2 on the wrong pin or on both pins. It also toggles the square-wave source in both modes and reads unused addresses and reserved bits, which would expose a pin that ignores the mode or a read path that leaks stale data.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W    = 8;
  localparam int CTRL_BITS = 3;
  localparam int NUM_FLAGS = 3;

  // control byte bit positions
  localparam int BIT_MODE = 2;
  localparam int BIT_A2EN = 1;
  localparam int BIT_A1EN = 0;

  // status byte bit positions
  localparam int BIT_OSF = 7;
  localparam int BIT_A2F = 1;
  localparam int BIT_A1F = 0;

  // flag slot numbering inside the flag bank
  localparam int SLOT_A1  = 0;
  localparam int SLOT_A2  = 1;
  localparam int SLOT_OSC = 2;

  typedef struct packed {
    logic mode;
    logic a2_en;
    logic a1_en;
  } ctrl_t;

  function automatic int slot_bit(input int slot);
    case (slot)
      SLOT_A1: return BIT_A1F;
      SLOT_A2: return BIT_A2F;
      default: return BIT_OSF;
    endcase
  endfunction

  function automatic logic slot_rst_val(input int slot);
    return (slot == SLOT_OSC) ? 1'b1 : 1'b0;
  endfunction
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [CTRL_BITS-1:0] wdata_i,
  output ctrl_t                ctrl_o
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d       = ctrl_q;
    ctrl_d.mode  = wdata_i[BIT_MODE];
    ctrl_d.a2_en = wdata_i[BIT_A2EN];
    ctrl_d.a1_en = wdata_i[BIT_A1EN];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en_i |=> (ctrl_o == ctrl_t'($past(wdata_i))));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_o));
endmodule

// File: rtl/rtc_sticky_flag.sv
module rtc_sticky_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= RST_VAL;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    set_i |=> flag_o);

  // R5
  flag_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!set_i && !flag_o) |=> !flag_o);

  // R5
  flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(clr_i));
endmodule

// File: rtl/rtc_irq_route.sv
module rtc_irq_route
  import rtc_irq_pkg::*;
(
  input  ctrl_t ctrl_i,
  input  logic  a1f_i,
  input  logic  a2f_i,
  input  logic  sqw_i,
  output logic  inta_no,
  output logic  sqw_intb_no
);
  logic a1_req;
  logic a2_req;
  logic a2_to_a;
  logic a2_to_b;

  always_comb begin
    a1_req  = a1f_i & ctrl_i.a1_en;
    a2_req  = a2f_i & ctrl_i.a2_en;
    a2_to_a = a2_req & ~ctrl_i.mode;
    a2_to_b = a2_req &  ctrl_i.mode;
    inta_no = ~(a1_req | a2_to_a);
    if (ctrl_i.mode) begin
      sqw_intb_no = ~a2_to_b;
    end else begin
      sqw_intb_no = sqw_i;
    end
  end
endmodule

// File: rtl/rtc_irq_router.sv
module rtc_irq_router
  import rtc_irq_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h0E,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'h0F,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alarm1_hit,
  input  logic              alarm2_hit,
  input  logic              osc_halted,
  input  logic              sqw_src,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              inta_n,
  output logic              sqw_intb_n
);
  logic                 rst_sync_n;
  logic                 ctrl_wr;
  logic                 stat_wr;
  ctrl_t                ctrl;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] flag_vec;
  logic                 unused_wbits;

  assign unused_wbits = ^reg_wdata[BIT_OSF-1:CTRL_BITS];

  rtc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  always_comb begin
    ctrl_wr = reg_wr & (reg_addr == CTRL_ADDR);
    stat_wr = reg_wr & (reg_addr == STAT_ADDR);
    set_vec[SLOT_A1]  = alarm1_hit;
    set_vec[SLOT_A2]  = alarm2_hit;
    set_vec[SLOT_OSC] = osc_halted;
  end

  rtc_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .wr_en_i (ctrl_wr),
    .wdata_i (reg_wdata[CTRL_BITS-1:0]),
    .ctrl_o  (ctrl)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    assign clr_vec[g] = stat_wr & ~reg_wdata[slot_bit(g)];
    rtc_sticky_flag #(.RST_VAL(slot_rst_val(g))) u_flag (
      .clk    (clk),
      .rst_ni (rst_sync_n),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .flag_o (flag_vec[g])
    );
  end

  rtc_irq_route u_route (
    .ctrl_i      (ctrl),
    .a1f_i       (flag_vec[SLOT_A1]),
    .a2f_i       (flag_vec[SLOT_A2]),
    .sqw_i       (sqw_src),
    .inta_no     (inta_n),
    .sqw_intb_no (sqw_intb_n)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_ADDR) begin
      reg_rdata[CTRL_BITS-1:0] = ctrl;
    end else if (reg_addr == STAT_ADDR) begin
      for (int s = 0; s < NUM_FLAGS; s++) begin
        reg_rdata[slot_bit(s)] = flag_vec[s];
      end
    end
  end

  // R8
  a1_pin_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_vec[SLOT_A1] && ctrl.a1_en) |-> !inta_n);

  // R9
  sqw_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl.mode |-> (sqw_intb_n == sqw_src));

  // R10
  quiet_pin_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctrl.a1_en && !ctrl.a2_en) |-> inta_n);

  // R6
  osc_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    osc_halted |=> reg_wr || (reg_addr != STAT_ADDR) || reg_rdata[BIT_OSF]);
endmodule

// File: tb/rtc_irq_router_test.sv
module rtc_irq_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alarm1_hit = 1'b0;
  logic       alarm2_hit = 1'b0;
  logic       osc_halted = 1'b0;
  logic       sqw_src = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       inta_n;
  logic       sqw_intb_n;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit [2:0] m_ctrl = 3'b000;
  bit       m_osf = 1'b1;
  bit       m_a2f = 1'b0;
  bit       m_a1f = 1'b0;

  rtc_irq_router uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .alarm1_hit (alarm1_hit),
    .alarm2_hit (alarm2_hit),
    .osc_halted (osc_halted),
    .sqw_src    (sqw_src),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .inta_n     (inta_n),
    .sqw_intb_n (sqw_intb_n)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl <= 3'b000;
      m_osf  <= 1'b1;
      m_a2f  <= 1'b0;
      m_a1f  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 8'h0E) m_ctrl <= reg_wdata[2:0];
      if (alarm1_hit) m_a1f <= 1'b1;
      else if (reg_wr && reg_addr == 8'h0F && !reg_wdata[0]) m_a1f <= 1'b0;
      if (alarm2_hit) m_a2f <= 1'b1;
      else if (reg_wr && reg_addr == 8'h0F && !reg_wdata[1]) m_a2f <= 1'b0;
      if (osc_halted) m_osf <= 1'b1;
      else if (reg_wr && reg_addr == 8'h0F && !reg_wdata[7]) m_osf <= 1'b0;
    end
  end

  task automatic tick(input string tag);
    bit [7:0] e_rd;
    bit       e_a;
    bit       e_b;
    bit       a1_on;
    bit       a2_on;
    @(negedge clk);
    #1;
    e_rd = 8'h00;
    if (reg_addr == 8'h0E) e_rd = {5'b0, m_ctrl};
    else if (reg_addr == 8'h0F) e_rd = {m_osf, 5'b0, m_a2f, m_a1f};
    a1_on = m_a1f && m_ctrl[0];
    a2_on = m_a2f && m_ctrl[1];
    e_a = !(a1_on || (a2_on && !m_ctrl[2]));
    e_b = m_ctrl[2] ? !a2_on : sqw_src;
    vectors++;
    if (reg_rdata !== e_rd || inta_n !== e_a || sqw_intb_n !== e_b) begin
      miscompares++;
      $display("FAIL %s: rdata=%h inta_n=%b sqw_intb_n=%b expected rdata=%h inta_n=%b sqw_intb_n=%b",
               tag, reg_rdata, inta_n, sqw_intb_n, e_rd, e_a, e_b);
    end
  endtask

  task automatic idle();
    alarm1_hit = 1'b0;
    alarm2_hit = 1'b0;
    osc_halted = 1'b0;
    reg_wr     = 1'b0;
  endtask

  task automatic wr(input bit [7:0] a, input bit [7:0] d, input string tag);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    tick(tag);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input bit [7:0] a, input string tag);
    reg_addr = a;
    tick(tag);
  endtask

  initial begin
    repeat (3) tick("R1");
    rst_n = 1'b1;
    repeat (3) tick("R1");
    rd(8'h0E, "R1");
    rd(8'h0F, "R1");

    // control register fields, reserved bits ignored
    wr(8'h0E, 8'hFF, "R2");
    rd(8'h0E, "R2");
    wr(8'h0E, 8'hF8, "R2");
    rd(8'h0E, "R2");
    wr(8'h0E, 8'h02, "R2");
    rd(8'h0E, "R2");
    wr(8'h0E, 8'h00, "R2");

    // read map, unused addresses
    rd(8'h00, "R3");
    rd(8'h0D, "R3");
    rd(8'hFF, "R3");
    rd(8'h0F, "R3");
    rd(8'h0F, "R3");

    // oscillator fault flag
    wr(8'h0F, 8'h7F, "R6");
    rd(8'h0F, "R6");
    osc_halted = 1'b1;
    rd(8'h0F, "R6");
    rd(8'h0F, "R6");
    wr(8'h0F, 8'h00, "R7");
    osc_halted = 1'b0;
    rd(8'h0F, "R6");
    wr(8'h0F, 8'h80, "R6");
    wr(8'h0F, 8'h00, "R6");
    rd(8'h0F, "R6");

    // alarm flags with enables off
    alarm1_hit = 1'b1;
    rd(8'h0F, "R4");
    alarm1_hit = 1'b0;
    rd(8'h0F, "R10");
    alarm2_hit = 1'b1;
    rd(8'h0F, "R4");
    alarm2_hit = 1'b0;
    for (int i = 0; i < 4; i++) begin
      sqw_src = ~sqw_src;
      rd(8'h0F, "R10");
    end

    // write-one no effect, selective clear
    wr(8'h0F, 8'hFF, "R5");
    rd(8'h0F, "R5");
    wr(8'h0F, 8'hFE, "R5");
    rd(8'h0F, "R5");
    wr(8'h0F, 8'hFD, "R5");
    rd(8'h0F, "R5");

    // alarm 1 on primary pin in both modes
    wr(8'h0E, 8'h01, "R8");
    alarm1_hit = 1'b1;
    rd(8'h0F, "R8");
    alarm1_hit = 1'b0;
    rd(8'h0F, "R8");
    wr(8'h0E, 8'h05, "R8");
    rd(8'h0F, "R8");
    wr(8'h0F, 8'hFE, "R11");
    rd(8'h0F, "R11");

    // alarm 2 routing
    wr(8'h0E, 8'h02, "R9");
    alarm2_hit = 1'b1;
    rd(8'h0F, "R9");
    alarm2_hit = 1'b0;
    for (int i = 0; i < 4; i++) begin
      sqw_src = ~sqw_src;
      rd(8'h0F, "R9");
    end
    wr(8'h0E, 8'h06, "R9");
    sqw_src = ~sqw_src;
    rd(8'h0F, "R9");
    sqw_src = ~sqw_src;
    rd(8'h0F, "R9");
    alarm1_hit = 1'b1;
    wr(8'h0E, 8'h07, "R9");
    alarm1_hit = 1'b0;
    rd(8'h0F, "R9");
    wr(8'h0E, 8'h05, "R11");
    rd(8'h0F, "R11");
    wr(8'h0E, 8'h04, "R11");
    rd(8'h0F, "R10");

    // set beats clear on alarm flags
    wr(8'h0E, 8'h03, "R7");
    alarm2_hit = 1'b1;
    alarm1_hit = 1'b1;
    wr(8'h0F, 8'h00, "R7");
    idle();
    rd(8'h0F, "R7");
    wr(8'h0F, 8'h00, "R11");
    rd(8'h0F, "R11");

    // reset mid-run returns to initial state
    wr(8'h0E, 8'h07, "R1");
    alarm1_hit = 1'b1;
    tick("R1");
    alarm1_hit = 1'b0;
    rst_n = 1'b0;
    rd(8'h0F, "R1");
    rd(8'h0E, "R1");
    rst_n = 1'b1;
    repeat (3) tick("R1");
    rd(8'h0F, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      miscompares++;
      $display("FAIL R1..: watchdog expired, run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule